// File: doc/BRIEF.md
# Sinc Decimation Filter with Settling Qualifier

This block converts the one-bit output of a delta-sigma modulator into signed multi-bit conversion results. A cascade of integrators runs at the modulator rate. A matching cascade of differentiators runs once per conversion period. The number of stages in use (the sinc order, 1 to 4) and the decimation ratio are both set by configuration. Each completed conversion pulls an active-low ready strobe low and presents a new result word.

The filter cannot tell when its analog input has jumped. The surrounding system reports such an event on a step input. From that event the block counts completed conversions and marks each result as settled or not. When the event falls on the first modulator sample of a period, the wait is one period per filter stage. When it falls anywhere else, that partial period is corrupted and one more period is needed. The ready strobe still fires for every result, so software can read every result and use the settled flag to discard the unsettled ones.

A restart pulse, or reset, loads the configuration and clears the whole filter. It then begins the settling count as a boundary-aligned event.

Top module: `sinc_decim_settle`

## Requirements
- R1: Bit 1 enters the filter as +1 and bit 0 as -1. Each result equals x cascaded moving sums of length R over this sequence, taken at the last sample of the period, where x is the order and R the ratio. All history before the latest restart or reset counts as zero.
- R2: A conversion period is R clocks, one modulator bit per clock, counted from the first clock after restart. drdy_n falls on the clock edge that takes in the last sample of each period, for every result, and at no other time.
- R3: After falling, drdy_n returns high one clock after a rd_ack pulse, or after floor(R/4) clocks low if no acknowledge arrives first. An acknowledge on the edge where a result is produced is ignored.
- R4: dout and settled change only on the edge where drdy_n falls, and hold their values between results.
- R5: A step_evt sampled on the first clock of a period (phase 0) marks the next x-1 results unsettled. Results from the x-th onward are settled. The first result counted is the one that ends that same period.
- R6: A step_evt sampled at any other phase marks the next x results unsettled. Results from the (x+1)-th onward are settled.
- R7: A step_evt that arrives while a settling count is still running restarts the count from the new event, using that event's phase.
- R8: Reset, or a restart pulse, latches the configuration and clears the filter state and the phase. It forces drdy_n high and dout and settled to 0, ignores the modulator bit of that clock, and starts an aligned settling count.
- R9: An order of 0 is treated as 1, and an order above 4 as 4. A ratio below 4 is treated as 4.
- R10: While reset is held, drdy_n is 1, dout is 0 and settled is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Filter restart pulse; loads configuration |
| cfg_order | input | 3 | Sinc order request |
| cfg_ratio | input | 8 | Decimation ratio request |
| mod_bit | input | 1 | Modulator bitstream, one bit per clock |
| step_evt | input | 1 | External input-step event |
| rd_ack | input | 1 | Result read acknowledge |
| drdy_n | output | 1 | Active-low result-ready strobe |
| dout | output | 33 | Signed conversion result |
| settled | output | 1 | Result is free of pre-step data |

## Verification
The bench places input steps both on the first sample of a period and at several later phases. A design that ignored the phase would mark the fourth-period third-order result settled one period too early, or one period too late in the aligned case. A second step arriving mid-settling catches a counter that keeps running from the first event. Results are compared against an independent moving-sum model for every order and for ratios of 5, 12 and 16. This exposes an integrator or comb picked from the wrong stage, as well as an off-by-one decimation instant. Out-of-range configuration and acknowledged strobes catch missing clamps and a strobe stuck low for the full timeout.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  // State of the ready strobe
  typedef enum logic {RDY_IDLE = 1'b0, RDY_LOW = 1'b1} rdy_state_t;
endpackage

// File: rtl/sinc_integrators.sv
module sinc_integrators #(
  parameter int STAGES = 4,
  parameter int ACC_W  = 33
) (
  input  logic                          clk,
  input  logic                          clr,
  input  logic                          mod_bit,
  output logic [STAGES-1:0][ACC_W-1:0]  int_nxt
);
  logic [STAGES-1:0][ACC_W-1:0] acc_q;
  logic [ACC_W-1:0]             sample;

  // +1 for a one, -1 (all ones) for a zero
  assign sample = mod_bit ? ACC_W'(1) : '1;

  for (genvar k = 0; k < STAGES; k++) begin : g_int
    if (k == 0) begin : g_first
      assign int_nxt[k] = acc_q[k] + sample;
    end else begin : g_next
      assign int_nxt[k] = acc_q[k] + int_nxt[k-1];
    end
  end

  // Two's complement wrap is harmless: the combs recover the true value
  always_ff @(posedge clk) begin
    if (clr) acc_q <= '0;
    else     acc_q <= int_nxt;
  end
endmodule

// File: rtl/sinc_combs.sv
module sinc_combs #(
  parameter int STAGES = 4,
  parameter int ACC_W  = 33,
  parameter int ORD_W  = 3
) (
  input  logic                          clk,
  input  logic                          clr,
  input  logic                          dec,
  input  logic [ORD_W-1:0]              order_q,
  input  logic [STAGES-1:0][ACC_W-1:0]  int_nxt,
  output logic [ACC_W-1:0]              dout
);
  logic [STAGES:0][ACC_W-1:0]   diff;
  logic [STAGES-1:0][ACC_W-1:0] dly_q;
  logic [ACC_W-1:0]             res;

  // Tap the integrator whose depth matches the order
  always_comb begin
    diff[0] = int_nxt[0];
    for (int k = 0; k < STAGES; k++)
      if (order_q == ORD_W'(k + 1)) diff[0] = int_nxt[k];
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_comb
    assign diff[k+1] = diff[k] - dly_q[k];
  end

  always_comb begin
    res = diff[1];
    for (int k = 0; k < STAGES; k++)
      if (order_q == ORD_W'(k + 1)) res = diff[k+1];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      dly_q <= '0;
      dout  <= '0;
    end else if (dec) begin
      dly_q <= diff[STAGES-1:0];
      dout  <= res;
    end
  end

  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (clr)
    !dec |=> $stable(dout));
endmodule

// File: rtl/sinc_settle_track.sv
module sinc_settle_track #(
  parameter  int MAX_ORDER = 4,
  parameter  int ORD_W     = 3,
  localparam int CNT_W     = $clog2(MAX_ORDER + 2)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             dec,
  input  logic             step,
  input  logic             aligned,
  input  logic [ORD_W-1:0] order_q,
  input  logic [ORD_W-1:0] order_new,
  output logic             settled
);
  logic [CNT_W-1:0] cnt_q, need_q, base, need_eff, cnt_inc;

  always_comb begin
    base     = step ? '0 : cnt_q;
    need_eff = need_q;
    if (step) need_eff = aligned ? CNT_W'(order_q) : CNT_W'(order_q) + 1'b1;
    cnt_inc  = (base == '1) ? base : base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q   <= '0;
      need_q  <= CNT_W'(order_new);
      settled <= 1'b0;
    end else begin
      need_q <= need_eff;
      if (dec) begin
        cnt_q   <= cnt_inc;
        settled <= (cnt_inc >= need_eff);
      end else begin
        cnt_q <= base;
      end
    end
  end

  assert_settle_on_result_R5: assert property (@(posedge clk) disable iff (clr)
    $rose(settled) |-> $past(dec));
  assert_mid_step_unsettled_R6: assert property (@(posedge clk) disable iff (clr)
    (step && dec) |=> !settled);
  assert_settle_hold_R4: assert property (@(posedge clk) disable iff (clr)
    !dec |=> $stable(settled));
endmodule

// File: rtl/sinc_drdy.sv
module sinc_drdy
  import sinc_pkg::*;
#(
  parameter int RATIO_W = 8
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               dec,
  input  logic [RATIO_W-1:0] ratio_q,
  input  logic               rd_ack,
  output logic               drdy_n
);
  rdy_state_t         st_q;
  logic [RATIO_W-1:0] tmr_q, hold_len;

  assign hold_len = ratio_q >> 2;

  always_ff @(posedge clk) begin
    if (clr) begin
      st_q  <= RDY_IDLE;
      tmr_q <= '0;
    end else if (dec) begin
      st_q  <= RDY_LOW;
      tmr_q <= '0;
    end else if (st_q == RDY_LOW) begin
      if (rd_ack || tmr_q == hold_len - 1'b1) st_q <= RDY_IDLE;
      else                                     tmr_q <= tmr_q + 1'b1;
    end
  end

  assign drdy_n = (st_q != RDY_LOW);

  // Independent count of low cycles for the window check
  logic [RATIO_W-1:0] chk_low;
  always_ff @(posedge clk) begin
    if (clr || drdy_n) chk_low <= '0;
    else               chk_low <= chk_low + 1'b1;
  end

  assert_drdy_fall_R2: assert property (@(posedge clk) disable iff (clr)
    $fell(drdy_n) |-> $past(dec));
  assert_drdy_window_R3: assert property (@(posedge clk) disable iff (clr)
    chk_low <= hold_len);
endmodule

// File: rtl/sinc_decim_settle.sv
module sinc_decim_settle #(
  parameter  int MAX_ORDER = 4,
  parameter  int RATIO_W   = 8,
  parameter  int MIN_RATIO = 4,
  localparam int ORD_W     = $clog2(MAX_ORDER + 1),
  localparam int ACC_W     = MAX_ORDER * RATIO_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [ORD_W-1:0]   cfg_order,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               mod_bit,
  input  logic               step_evt,
  input  logic               rd_ack,
  output logic               drdy_n,
  output logic [ACC_W-1:0]   dout,
  output logic               settled
);
  logic [ORD_W-1:0]   order_q, order_cl;
  logic [RATIO_W-1:0] ratio_q, ratio_cl, phase_q;
  logic               flush, dec, aligned;
  logic [MAX_ORDER-1:0][ACC_W-1:0] int_nxt;

  always_comb begin
    order_cl = cfg_order;
    if (cfg_order == '0)                          order_cl = ORD_W'(1);
    else if (cfg_order > ORD_W'(MAX_ORDER))       order_cl = ORD_W'(MAX_ORDER);
    ratio_cl = (cfg_ratio < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : cfg_ratio;
  end

  assign flush   = rst | restart;
  assign dec     = !flush && (phase_q == ratio_q - 1'b1);
  assign aligned = (phase_q == '0);

  always_ff @(posedge clk) begin
    if (flush) begin
      order_q <= order_cl;
      ratio_q <= ratio_cl;
      phase_q <= '0;
    end else begin
      phase_q <= dec ? '0 : phase_q + 1'b1;
    end
  end

  sinc_integrators #(.STAGES(MAX_ORDER), .ACC_W(ACC_W)) u_int (
    .clk(clk), .clr(flush), .mod_bit(mod_bit), .int_nxt(int_nxt));

  sinc_combs #(.STAGES(MAX_ORDER), .ACC_W(ACC_W), .ORD_W(ORD_W)) u_comb (
    .clk(clk), .clr(flush), .dec(dec), .order_q(order_q),
    .int_nxt(int_nxt), .dout(dout));

  sinc_settle_track #(.MAX_ORDER(MAX_ORDER), .ORD_W(ORD_W)) u_settle (
    .clk(clk), .clr(flush), .dec(dec), .step(step_evt), .aligned(aligned),
    .order_q(order_q), .order_new(order_cl), .settled(settled));

  sinc_drdy #(.RATIO_W(RATIO_W)) u_rdy (
    .clk(clk), .clr(flush), .dec(dec), .ratio_q(ratio_q),
    .rd_ack(rd_ack), .drdy_n(drdy_n));

  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (flush)
    dec |=> (phase_q == '0));
endmodule

// File: tb/sinc_decim_settle_tb.sv
`timescale 1ns/1ps
module sinc_decim_settle_tb;
  localparam int MAXO = 4;
  localparam int RW   = 8;
  localparam int AW   = MAXO * RW + 1;
  localparam int MAXS = 512;
  localparam int NONE = 15;

  // {order[31:29], ratio[28:21], step period[20:17], step phase[16:9], periods[8:4], seed[3:0]}
  localparam logic [31:0] VEC [8] = '{
    {3'd1, 8'd8,  4'd15, 8'd0, 5'd6,  4'd1},
    {3'd2, 8'd8,  4'd2,  8'd0, 5'd8,  4'd2},
    {3'd3, 8'd8,  4'd2,  8'd0, 5'd8,  4'd3},
    {3'd3, 8'd8,  4'd2,  8'd5, 5'd9,  4'd4},
    {3'd4, 8'd12, 4'd1,  8'd0, 5'd9,  4'd5},
    {3'd4, 8'd12, 4'd1,  8'd7, 5'd10, 4'd6},
    {3'd1, 8'd16, 4'd2,  8'd3, 5'd6,  4'd7},
    {3'd2, 8'd5,  4'd3,  8'd4, 5'd9,  4'd8}
  };

  logic clk = 1'b0, rst = 1'b1, restart = 1'b0, mod_bit = 1'b0, step_evt = 1'b0, rd_ack = 1'b0;
  logic [2:0]    cfg_order = 3'd1;
  logic [RW-1:0] cfg_ratio = 8'd8;
  logic          drdy_n, settled;
  logic [AW-1:0] dout;

  always #2.5 clk = ~clk;

  sinc_decim_settle u_dut (
    .clk(clk), .rst(rst), .restart(restart), .cfg_order(cfg_order), .cfg_ratio(cfg_ratio),
    .mod_bit(mod_bit), .step_evt(step_evt), .rd_ack(rd_ack),
    .drdy_n(drdy_n), .dout(dout), .settled(settled));

  int errors = 0, checks = 0;
  int m [0:MAXO][0:MAXS-1];
  int t, ord_e, r_e, set_cnt, set_need, low_cnt;
  bit prev_drdy, prev_set, ack_pend, win_acked, auto_ack, stepped;
  logic [AW-1:0] prev_dout;
  string set_tag, ctx;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", ctx, tag, act, exp);
    end
  endtask

  task automatic restart_cfg(input int o, input int r);
    cfg_order = 3'(o);
    cfg_ratio = RW'(r);
    restart = 1'b1;
    @(posedge clk); @(negedge clk);
    restart = 1'b0;
    ord_e = (o == 0) ? 1 : (o > MAXO ? MAXO : o);
    r_e   = (r < 4) ? 4 : r;
    t = 0; set_cnt = 0; set_need = ord_e; set_tag = "R8 settling after restart";
    ack_pend = 0; win_acked = 0; low_cnt = 0; stepped = 0;
    // R8: restart clears outputs
    chk(drdy_n === 1'b1, "R8 drdy_n after restart", drdy_n, 1);
    chk(dout === '0, "R8 dout after restart", longint'($signed(dout)), 0);
    chk(settled === 1'b0, "R8 settled after restart", settled, 0);
    prev_drdy = drdy_n; prev_dout = dout; prev_set = settled;
  endtask

  task automatic push(input bit b, input bit stp, input bit r7);
    int ph;
    bit exp_set;
    int exp_low;
    ph = t % r_e;
    mod_bit = b; step_evt = stp;
    rd_ack = ack_pend;
    if (ack_pend) begin win_acked = 1; ack_pend = 0; end
    m[0][t] = b ? 1 : -1;
    for (int k = 1; k <= MAXO; k++)
      m[k][t] = (t > 0 ? m[k][t-1] : 0) + m[k-1][t] - (t >= r_e ? m[k-1][t-r_e] : 0);
    if (stp) begin
      set_cnt  = 0;
      set_need = (ph == 0) ? ord_e : ord_e + 1;
      if (r7 && stepped) set_tag = "R7 restarted settling";
      else if (ph == 0)  set_tag = "R5 aligned-step settling";
      else               set_tag = "R6 mid-period-step settling";
      stepped = 1;
    end
    @(posedge clk); @(negedge clk);
    step_evt = 1'b0; rd_ack = 1'b0;
    if (ph == r_e - 1) begin
      set_cnt++;
      exp_set = (set_cnt >= set_need);
      chk(prev_drdy && !drdy_n, "R2 drdy_n falls at period end", drdy_n, 0);
      chk($signed(dout) == longint'(m[ord_e][t]), "R1 result", longint'($signed(dout)), m[ord_e][t]);
      chk(settled === exp_set, set_tag, settled, exp_set);
      low_cnt = 1; ack_pend = auto_ack; win_acked = 0;
    end else begin
      chk(dout === prev_dout && settled === prev_set, "R4 outputs held", longint'($signed(dout)), longint'($signed(prev_dout)));
      if (!prev_drdy) begin
        if (drdy_n) begin
          exp_low = win_acked ? 1 : r_e / 4;
          chk(low_cnt == exp_low, "R3 drdy_n low window", low_cnt, exp_low);
        end else low_cnt++;
      end else begin
        chk(drdy_n === 1'b1, "R2 no fall mid-period", drdy_n, 1);
      end
    end
    prev_drdy = drdy_n; prev_dout = dout; prev_set = settled;
    t++;
  endtask

  task automatic run(input int o, input int r, input int periods, input int s1pd, input int s1ph,
                     input int s2pd, input int s2ph, input int seed, input bit r7);
    logic [7:0] lfsr;
    bit after, stp, b;
    restart_cfg(o, r);
    lfsr = 8'hA5 ^ 8'(seed);
    after = 0;
    for (int p = 0; p < periods; p++) begin
      for (int q = 0; q < r_e; q++) begin
        stp = (p == s1pd && q == s1ph) || (p == s2pd && q == s2ph);
        if (stp) after = ~after;
        b = after ? (lfsr[0] | lfsr[3]) : (lfsr[0] & lfsr[3]);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        push(b, stp, r7);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ctx = "reset";
    auto_ack = 0;
    repeat (4) @(negedge clk);
    // R10: outputs while reset is held
    chk(drdy_n === 1'b1, "R10 drdy_n in reset", drdy_n, 1);
    chk(dout === '0, "R10 dout in reset", longint'($signed(dout)), 0);
    chk(settled === 1'b0, "R10 settled in reset", settled, 0);
    rst = 1'b0;

    // Vector table walk: R1 R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 8; v++) begin
      ctx = $sformatf("vec%0d", v);
      run(int'(VEC[v][31:29]), int'(VEC[v][28:21]), int'(VEC[v][8:4]),
          int'(VEC[v][20:17]), int'(VEC[v][16:9]), NONE, 0, int'(VEC[v][3:0]), 1'b0);
    end

    // R7: second aligned step while the first is still settling
    ctx = "R7 double step";
    run(3, 8, 7, 1, 0, 2, 0, 9, 1'b1);
    // R7: second step lands mid-period
    ctx = "R7 double step mid";
    run(2, 8, 7, 1, 3, 2, 6, 10, 1'b1);

    // R3: acknowledge ends the low window early
    ctx = "R3 ack";
    auto_ack = 1;
    run(2, 16, 4, NONE, 0, NONE, 0, 11, 1'b0);
    auto_ack = 0;

    // R9: configuration clamps (order 0 -> 1, ratio 2 -> 4; order 7 -> 4; ratio 3 -> 4)
    ctx = "R9 clamp low";
    run(0, 2, 6, 2, 1, NONE, 0, 12, 1'b0);
    ctx = "R9 clamp high";
    run(7, 8, 7, NONE, 0, NONE, 0, 13, 1'b0);
    ctx = "R9 clamp ratio";
    run(3, 3, 8, 3, 0, NONE, 0, 14, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule